// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block drives the internal synchronous reset of a small microcontroller core. Three sources can request a reset: the external reset pin, a power-on pulse, and a watchdog timeout that the watchdog timer reports through a flag. The block also keeps two cause flags that software reads after restart. One flag marks a power-on and the other marks a watchdog reset. When both flags are clear, software takes the last reset to be an external one, so the block keeps no flag for the pin.

A machine cycle has four phases, one clock each. The block reads the pin only in the last phase of each machine cycle. It keeps the core in reset while the pin is seen high, and for two more machine cycles after the pin is seen low. When the watchdog flag and the watchdog reset enable are both high, the block counts 512 clocks and then holds the core in reset for two machine cycles. If the flag or the enable drops before the count ends, the pending reset is dropped. A power-on pulse holds the core in reset for as long as it lasts and for two machine cycles after it ends.

Top module: `reset_sequencer`

## Requirements
- R1: While rst_ni is low, core_rst_o is 1 and both cause flags are 0. After rst_ni rises, core_rst_o stays 1 through the next 7 rising edges and goes to 0 after the 8th.
- R2: rst_pin_i is sampled only on rising edges where phase_i equals 2'b11 (the fourth phase). A high sample sets core_rst_o to 1 right after that edge. Pin activity that no such edge sees has no effect on core_rst_o.
- R3: core_rst_o stays 1 while the fourth-phase samples are high. After the first low sample it stays 1 for two more machine cycles and goes to 0 after the second fourth-phase edge that follows, which is 8 clocks after the low sample.
- R4: When wdt_flag_i and wdt_rst_en_i are both high, core_rst_o rises after the 512th consecutive rising edge at which both are seen high.
- R5: If wdt_flag_i or wdt_rst_en_i is low on any edge before the 512th, the pending watchdog reset is dropped and the count starts again from zero. With wdt_rst_en_i low, the watchdog flag never causes a reset.
- R6: A watchdog flag that stays high fires only one reset. The flag must go low before the watchdog can fire again.
- R7: A watchdog reset holds core_rst_o at 1 for exactly 8 clocks (two machine cycles) when no other source is active.
- R8: core_rst_o is 1 after every edge at which por_i is high. After por_i falls it stays 1 for 8 more clocks.
- R9: por_flag_o is set by por_i and is cleared only by clr_por_flag_i. por_i wins when both are high.
- R10: wdt_flag_o is set on the edge at which the watchdog reset fires. It is cleared by clr_wdt_flag_i or by por_i. A firing wins over a software clear on the same edge, and por_i wins over a firing.
- R11: An external reset leaves both cause flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the sequencer |
| phase_i | input | 2 | Current machine-cycle phase; 2'b11 is the fourth phase |
| rst_pin_i | input | 1 | External reset pin, active high |
| por_i | input | 1 | Power-on pulse, active high |
| wdt_flag_i | input | 1 | Watchdog timeout flag |
| wdt_rst_en_i | input | 1 | Lets the watchdog flag cause a reset |
| clr_por_flag_i | input | 1 | Software clear of the power-on cause flag |
| clr_wdt_flag_i | input | 1 | Software clear of the watchdog cause flag |
| core_rst_o | output | 1 | Internal synchronous reset to the core |
| por_flag_o | output | 1 | Power-on cause flag |
| wdt_flag_o | output | 1 | Watchdog cause flag |

## Verification
A watchdog firing can fall on the same edge as a write to the cause flags, either a software clear of the watchdog flag or a power-on pulse. The bench counts 511 edges after it raises the watchdog flag and raises the clear, or por_i, for the 512th edge only. It then judges the result by wdt_flag_o and core_rst_o. The flag must stay set after a software clear, must read clear after a power-on, and the core reset must be asserted in both cases.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef logic [1:0] phase_t;
  localparam phase_t PH_C4 = 2'b11;
endpackage

// File: rtl/rs_pin_sampler.sv
module rs_pin_sampler
  import rstseq_pkg::*;
#(
  parameter int HOLD_MC = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_t phase_i,
  input  logic   rst_pin_i,
  output logic   ext_active_o
);
  localparam int LOAD = HOLD_MC + 1;
  localparam int CW   = $clog2(LOAD + 1);

  logic [CW-1:0] cnt_q;

  // reload while pin high, count down on each low C4 sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (phase_i == PH_C4) begin
      if (rst_pin_i)          cnt_q <= CW'(LOAD);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ext_active_o = (cnt_q != '0);

  // R2
  ext_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != PH_C4) |=> $stable(cnt_q));
  // R2
  ext_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_C4 && rst_pin_i) |=> ext_active_o);
endmodule

// File: rtl/rs_wdt_delay.sv
module rs_wdt_delay #(
  parameter int DELAY = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic wdt_flag_i,
  input  logic wdt_en_i,
  output logic fire_o
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          arm;

  assign arm    = wdt_flag_i && wdt_en_i && !done_q;
  assign fire_o = arm && (cnt_q == CW'(DELAY - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (por_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (!arm || fire_o) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
      // one shot per flag assertion
      if (fire_o)           done_q <= 1'b1;
      else if (!wdt_flag_i) done_q <= 1'b0;
    end
  end

  // R5
  wdt_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wdt_flag_i && wdt_en_i) |=> (cnt_q == '0));
  // R6
  wdt_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/rs_hold_timer.sv
module rs_hold_timer #(
  parameter int HOLD_CLKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic active_o
);
  localparam int CW = $clog2(HOLD_CLKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= CW'(HOLD_CLKS);
    else if (load_i)       cnt_q <= CW'(HOLD_CLKS);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  // R7
  hold_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> active_o);
  // R7
  hold_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rs_cause_flags.sv
module rs_cause_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic wdt_fire_i,
  input  logic clr_por_i,
  input  logic clr_wdt_i,
  output logic por_flag_o,
  output logic wdt_flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_flag_o <= 1'b0;
      wdt_flag_o <= 1'b0;
    end else begin
      if (por_i)          por_flag_o <= 1'b1;
      else if (clr_por_i) por_flag_o <= 1'b0;
      // power-on beats watchdog set, set beats software clear
      if (por_i)           wdt_flag_o <= 1'b0;
      else if (wdt_fire_i) wdt_flag_o <= 1'b1;
      else if (clr_wdt_i)  wdt_flag_o <= 1'b0;
    end
  end

  // R10
  wdt_flag_por_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (!wdt_flag_o && por_flag_o));
  // R10
  wdt_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_fire_i && !por_i) |=> wdt_flag_o);
  // R9
  por_flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_por_i && !por_i) |=> !por_flag_o);
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int WDT_DELAY = 512,
  parameter int HOLD_MC   = 2,
  parameter int PHASES    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] phase_i,
  input  logic       rst_pin_i,
  input  logic       por_i,
  input  logic       wdt_flag_i,
  input  logic       wdt_rst_en_i,
  input  logic       clr_por_flag_i,
  input  logic       clr_wdt_flag_i,
  output logic       core_rst_o,
  output logic       por_flag_o,
  output logic       wdt_flag_o
);
  localparam int HOLD_CLKS = HOLD_MC * PHASES;

  logic ext_active;
  logic hold_active;
  logic wdt_fire;

  rs_pin_sampler #(.HOLD_MC(HOLD_MC)) u_pin (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phase_i      (phase_t'(phase_i)),
    .rst_pin_i    (rst_pin_i),
    .ext_active_o (ext_active)
  );

  rs_wdt_delay #(.DELAY(WDT_DELAY)) u_wdt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_i      (por_i),
    .wdt_flag_i (wdt_flag_i),
    .wdt_en_i   (wdt_rst_en_i),
    .fire_o     (wdt_fire)
  );

  rs_hold_timer #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (por_i || wdt_fire),
    .active_o (hold_active)
  );

  rs_cause_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_i      (por_i),
    .wdt_fire_i (wdt_fire),
    .clr_por_i  (clr_por_flag_i),
    .clr_wdt_i  (clr_wdt_flag_i),
    .por_flag_o (por_flag_o),
    .wdt_flag_o (wdt_flag_o)
  );

  assign core_rst_o = ext_active || hold_active;

  // R8
  por_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> core_rst_o);
  // R11
  ext_flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && !wdt_fire && !clr_por_flag_i && !clr_wdt_flag_i) |=>
      ($stable(por_flag_o) && $stable(wdt_flag_o)));
endmodule

// File: tb/sim_reset_sequencer.sv
`timescale 1ns/1ps
module sim_reset_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cyc = '0;
  logic        pin = 1'b0, por = 1'b0, wflag = 1'b0, wen = 1'b1;
  logic        clr_por = 1'b0, clr_wdt = 1'b0;
  logic        core_rst, por_flag, wdt_flag;
  logic [1:0]  phase;
  int          n_chk = 0, n_err = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign phase = cyc[1:0];

  reset_sequencer u0 (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .rst_pin_i(pin), .por_i(por),
    .wdt_flag_i(wflag), .wdt_rst_en_i(wen), .clr_por_flag_i(clr_por),
    .clr_wdt_flag_i(clr_wdt), .core_rst_o(core_rst), .por_flag_o(por_flag),
    .wdt_flag_o(wdt_flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // core reset must stay low for n clocks
  task automatic quiet(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (core_rst) hits++;
    end
    chk(req, hits != 0, 1'b0);
  endtask

  task automatic t_reset;
    step(0);
    chk("R1 reset core_rst", core_rst, 1'b1);
    chk("R1 reset por_flag", por_flag, 1'b0);
    chk("R1 reset wdt_flag", wdt_flag, 1'b0);
    rst_n = 1'b1;
    step(7);
    chk("R1 hold after release", core_rst, 1'b1);
    step(1);
    chk("R1 release end", core_rst, 1'b0);
  endtask

  task automatic t_por;
    por = 1'b1;
    step(1);
    chk("R8 por asserts", core_rst, 1'b1);
    chk("R9 por flag set", por_flag, 1'b1);
    chk("R10 por clears wdt flag", wdt_flag, 1'b0);
    por = 1'b0;
    step(7);
    chk("R8 por stretch", core_rst, 1'b1);
    step(1);
    chk("R8 por end", core_rst, 1'b0);
  endtask

  task automatic t_ext_short;
    do @(negedge clk); while (phase != 2'd0);
    pin = 1'b1;
    step(3);
    pin = 1'b0;
    chk("R2 non-C4 pulse ignored", core_rst, 1'b0);
    quiet(12, "R2 non-C4 pulse quiet");
  endtask

  task automatic t_ext_pulse;
    do @(negedge clk); while (phase != 2'd2);
    pin = 1'b1;
    step(1);
    chk("R2 no sample off C4", core_rst, 1'b0);
    step(1);
    chk("R2 C4 sample asserts", core_rst, 1'b1);
    step(11);
    chk("R3 held while pin high", core_rst, 1'b1);
    do @(negedge clk); while (phase != 2'd3);
    pin = 1'b0;
    step(1);
    chk("R3 stretch first", core_rst, 1'b1);
    step(7);
    chk("R3 stretch last", core_rst, 1'b1);
    step(1);
    chk("R3 stretch end", core_rst, 1'b0);
    chk("R11 por flag kept", por_flag, 1'b1);
    chk("R11 wdt flag kept", wdt_flag, 1'b0);
  endtask

  task automatic t_clr_por;
    clr_por = 1'b1;
    step(1);
    clr_por = 1'b0;
    chk("R9 por flag cleared", por_flag, 1'b0);
    chk("R10 wdt flag untouched", wdt_flag, 1'b0);
  endtask

  // raise flag, run to the edge before firing
  task automatic wdt_arm;
    wflag = 1'b1;
    step(511);
    chk("R4 no reset before 512", core_rst, 1'b0);
  endtask

  task automatic t_wdt_fire;
    wdt_arm();
    chk("R10 flag clear before fire", wdt_flag, 1'b0);
    step(1);
    chk("R4 fires at 512", core_rst, 1'b1);
    chk("R10 wdt flag set", wdt_flag, 1'b1);
    step(7);
    chk("R7 hold last clock", core_rst, 1'b1);
    step(1);
    chk("R7 hold end", core_rst, 1'b0);
    quiet(600, "R6 no refire");
    wflag = 1'b0;
    step(1);
  endtask

  task automatic t_wdt_cancel;
    wdt_arm();
    wflag = 1'b0;
    quiet(600, "R5 cancel by flag");
    wflag = 1'b1;
    wen = 1'b0;
    quiet(700, "R5 enable low");
    wflag = 1'b0;
    wen = 1'b1;
    step(1);
  endtask

  task automatic t_clr_wdt;
    clr_wdt = 1'b1;
    step(1);
    clr_wdt = 1'b0;
    chk("R10 wdt flag cleared", wdt_flag, 1'b0);
  endtask

  task automatic t_fire_vs_clear;
    wdt_arm();
    clr_wdt = 1'b1;
    step(1);
    clr_wdt = 1'b0;
    chk("R10 fire beats clear", wdt_flag, 1'b1);
    chk("R4 fire with clear", core_rst, 1'b1);
    wflag = 1'b0;
    step(12);
  endtask

  task automatic t_fire_vs_por;
    wdt_arm();
    por = 1'b1;
    step(1);
    por = 1'b0;
    wflag = 1'b0;
    chk("R10 por beats fire", wdt_flag, 1'b0);
    chk("R9 por flag on collision", por_flag, 1'b1);
    chk("R8 reset on collision", core_rst, 1'b1);
    step(12);
    chk("R8 collision ends", core_rst, 1'b0);
  endtask

  initial begin
    t_reset();
    t_por();
    t_ext_short();
    t_ext_pulse();
    t_clr_por();
    t_wdt_fire();
    t_wdt_cancel();
    t_clr_wdt();
    t_fire_vs_clear();
    t_fire_vs_por();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL timeout: got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule